// File: doc/BRIEF.md
# Per-Source Circular Receive Window Allocator

This block sits at the receive side of a node on a shared multi-master bus and decides where each inbound message is written. The node's receive region is cut into equal sub-windows, one per possible sender slot, so traffic from different senders can never overlap. Each sub-window is used as a circular store: messages from one sender are placed one after another, and a message that would run past the end of its sub-window is placed at the sub-window start instead.

A request names the source slot and the message length. One clock later the block answers with the absolute write address, a status code and the echoed slot, and the slot's offset advances by the length. Requests of an illegal length or from the receiver's own slot are refused without touching any offset. A clear input returns every offset to zero. The region base and the receiver's own slot number are static configuration inputs, set once when the node joins the system.

Top module: `win_alloc`

## Requirements
- R1: After reset every slot offset is zero, rsp_valid_o is low, and the first accepted request from slot s returns base_i + s * SUBWIN (SUBWIN = 2**SUBWIN_LOG2 bytes).
- R2: Every request sampled with req_valid_i high yields exactly one response with rsp_valid_o high in the following cycle, with rsp_slot_o equal to the requested slot; no response appears in a cycle that follows no request.
- R3: Consecutive accepted requests from one slot that fit return addresses that grow by the previous message length.
- R4: When offset + length exceeds SUBWIN the message is placed at offset zero of the slot's sub-window and the new offset equals the length; an exact fit (offset + length = SUBWIN) does not restart. Offsets never exceed SUBWIN.
- R5: A request from one slot leaves the offsets of all other slots unchanged.
- R6: A length of zero or greater than SUBWIN gives rsp_status_o = 1 (bad length), rsp_addr_o = 0, and leaves the slot's offset unchanged.
- R7: A request whose slot equals self_slot_i gives rsp_status_o = 2 (own slot), rsp_addr_o = 0, and changes no offset; this code takes precedence over a bad length. An accepted request gives rsp_status_o = 0.
- R8: clear_i high zeroes all offsets; a request in the same cycle is placed as if its offset were already zero, and its advance is kept.
- R9: An accepted request of length L from slot s always lands in [base_i + s*SUBWIN, base_i + (s+1)*SUBWIN - L]; base_i must be a multiple of NUM_SLOTS * SUBWIN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| base_i | input | ADDR_W | Receive region base, aligned to the region size |
| self_slot_i | input | SLOT_W | Slot number of this receiver |
| clear_i | input | 1 | Zero all offsets |
| req_valid_i | input | 1 | Request present |
| req_slot_i | input | SLOT_W | Source slot of the message |
| req_len_i | input | LEN_W | Message length in bytes |
| rsp_valid_o | output | 1 | Response present, one cycle after the request |
| rsp_addr_o | output | ADDR_W | Absolute write address, zero on refusal |
| rsp_status_o | output | 2 | 0 accepted, 1 bad length, 2 own slot |
| rsp_slot_o | output | SLOT_W | Echo of the requested slot |

## Verification
The bench aims at the restart boundary from both sides: an exact fit that must not restart and a one-byte overflow that must, so a design using >= instead of > moves the address to the window start one message early. Refused requests are followed by a legal request from the same slot, which exposes a design that advanced the offset on a zero or oversized length or on its own slot. A clear issued together with a request checks that the request sees a zero offset and keeps its own advance, which a design applying the clear after the write would lose. A long stream of back-to-back mixed requests catches cross-slot corruption and any dropped or duplicated response.

// File: rtl/win_alloc_pkg.sv
package win_alloc_pkg;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_BAD_LEN  = 2'd1,
        ST_OWN_SLOT = 2'd2
    } win_status_e;

endpackage

// File: rtl/win_req_check.sv
module win_req_check
    import win_alloc_pkg::*;
#(
    parameter int SLOT_W      = 3,
    parameter int LEN_W       = 8,
    parameter int SUBWIN_LOG2 = 8
) (
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [SLOT_W-1:0] self_slot_i,
    input  logic [LEN_W-1:0]  len_i,
    output win_status_e       status_o
);
    localparam logic [LEN_W:0] SUBWIN = (LEN_W+1)'(1) << SUBWIN_LOG2;

    always_comb begin
        if (slot_i == self_slot_i) begin
            status_o = ST_OWN_SLOT;
        end else if ((len_i == '0) || ({1'b0, len_i} > SUBWIN)) begin
            status_o = ST_BAD_LEN;
        end else begin
            status_o = ST_OK;
        end
    end
endmodule

// File: rtl/win_fit_calc.sv
module win_fit_calc #(
    parameter int LEN_W       = 8,
    parameter int SUBWIN_LOG2 = 8,
    localparam int OFF_W      = SUBWIN_LOG2 + 1
) (
    input  logic [OFF_W-1:0] cur_off_i,
    input  logic [LEN_W-1:0] len_i,
    output logic [OFF_W-1:0] start_off_o,
    output logic [OFF_W-1:0] next_off_o,
    output logic             restart_o
);
    localparam int SUM_W = LEN_W + 2;
    localparam logic [SUM_W-1:0] SUBWIN = SUM_W'(1) << SUBWIN_LOG2;

    logic [SUM_W-1:0] end_pos;
    logic [SUM_W-1:0] next_wide;

    always_comb begin
        end_pos     = SUM_W'(cur_off_i) + SUM_W'(len_i);
        restart_o   = (end_pos > SUBWIN);
        start_off_o = restart_o ? '0 : cur_off_i;
        next_wide   = SUM_W'(start_off_o) + SUM_W'(len_i);
        next_off_o  = next_wide[OFF_W-1:0];
    end
endmodule

// File: rtl/win_offset_table.sv
module win_offset_table #(
    parameter int NUM_SLOTS   = 8,
    parameter int SUBWIN_LOG2 = 8,
    localparam int SLOT_W     = $clog2(NUM_SLOTS),
    localparam int OFF_W      = SUBWIN_LOG2 + 1
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              clr_i,
    input  logic [SLOT_W-1:0] rd_slot_i,
    output logic [OFF_W-1:0]  rd_off_o,
    input  logic              wr_en_i,
    input  logic [SLOT_W-1:0] wr_slot_i,
    input  logic [OFF_W-1:0]  wr_off_i
);
    localparam logic [OFF_W-1:0] SUBWIN = OFF_W'(1) << SUBWIN_LOG2;

    typedef struct {
        logic [OFF_W-1:0] off [NUM_SLOTS];
    } tbl_t;

    tbl_t tbl_d, tbl_q;

    // A clear makes every entry read as zero in the same cycle.
    assign rd_off_o = clr_i ? '0 : tbl_q.off[rd_slot_i];

    always_comb begin
        tbl_d = tbl_q;
        if (clr_i) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                tbl_d.off[i] = '0;
            end
        end
        if (wr_en_i) begin
            tbl_d.off[wr_slot_i] = wr_off_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                tbl_q.off[i] <= '0;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    for (genvar gi = 0; gi < NUM_SLOTS; gi++) begin : g_chk
        // R4: no offset ever points past its sub-window.
        assert_offset_bound_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            tbl_q.off[gi] <= SUBWIN);

        // R5, R6: an entry only moves when written or cleared.
        assert_entry_hold_R5: assert property (@(posedge clk_i) disable iff (rst_i)
            (!clr_i && !(wr_en_i && (wr_slot_i == SLOT_W'(gi)))) |=> $stable(tbl_q.off[gi]));

        // R8: a clear without a write to this entry leaves it at zero.
        assert_clear_zero_R8: assert property (@(posedge clk_i) disable iff (rst_i)
            (clr_i && !(wr_en_i && (wr_slot_i == SLOT_W'(gi)))) |=> (tbl_q.off[gi] == '0));
    end
endmodule

// File: rtl/win_alloc.sv
module win_alloc
    import win_alloc_pkg::*;
#(
    parameter int NUM_SLOTS   = 8,
    parameter int ADDR_W      = 32,
    parameter int SUBWIN_LOG2 = 8,
    parameter int LEN_W       = 10,
    localparam int SLOT_W     = $clog2(NUM_SLOTS)
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [SLOT_W-1:0] self_slot_i,
    input  logic              clear_i,
    input  logic              req_valid_i,
    input  logic [SLOT_W-1:0] req_slot_i,
    input  logic [LEN_W-1:0]  req_len_i,
    output logic              rsp_valid_o,
    output logic [ADDR_W-1:0] rsp_addr_o,
    output logic [1:0]        rsp_status_o,
    output logic [SLOT_W-1:0] rsp_slot_o
);
    localparam int OFF_W = SUBWIN_LOG2 + 1;
    localparam int REL_W = SLOT_W + SUBWIN_LOG2;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        win_status_e       status;
        logic [SLOT_W-1:0] slot;
    } rsp_t;

    rsp_t rsp_d, rsp_q;

    win_status_e      chk_status;
    logic [OFF_W-1:0] cur_off;
    logic [OFF_W-1:0] start_off;
    logic [OFF_W-1:0] next_off;
    logic             restart;
    logic             accept;
    logic [REL_W-1:0] rel_addr;

    win_req_check #(
        .SLOT_W(SLOT_W), .LEN_W(LEN_W), .SUBWIN_LOG2(SUBWIN_LOG2)
    ) i_check (
        .slot_i(req_slot_i), .self_slot_i(self_slot_i),
        .len_i(req_len_i), .status_o(chk_status)
    );

    win_offset_table #(
        .NUM_SLOTS(NUM_SLOTS), .SUBWIN_LOG2(SUBWIN_LOG2)
    ) i_table (
        .clk_i(clk_i), .rst_i(rst_i), .clr_i(clear_i),
        .rd_slot_i(req_slot_i), .rd_off_o(cur_off),
        .wr_en_i(accept), .wr_slot_i(req_slot_i), .wr_off_i(next_off)
    );

    win_fit_calc #(
        .LEN_W(LEN_W), .SUBWIN_LOG2(SUBWIN_LOG2)
    ) i_fit (
        .cur_off_i(cur_off), .len_i(req_len_i),
        .start_off_o(start_off), .next_off_o(next_off), .restart_o(restart)
    );

    assign accept   = req_valid_i && (chk_status == ST_OK);
    // start_off is below SUBWIN whenever the request is accepted.
    assign rel_addr = {req_slot_i, start_off[SUBWIN_LOG2-1:0]};

    always_comb begin
        rsp_d        = rsp_q;
        rsp_d.vld    = req_valid_i;
        if (req_valid_i) begin
            rsp_d.status = chk_status;
            rsp_d.slot   = req_slot_i;
            rsp_d.addr   = accept ? (base_i + ADDR_W'(rel_addr)) : '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            rsp_q <= '{vld: 1'b0, addr: '0, status: ST_OK, slot: '0};
        end else begin
            rsp_q <= rsp_d;
        end
    end

    assign rsp_valid_o  = rsp_q.vld;
    assign rsp_addr_o   = rsp_q.addr;
    assign rsp_status_o = rsp_q.status;
    assign rsp_slot_o   = rsp_q.slot;

    // R2: one response per request, one cycle later, for the same slot.
    assert_rsp_follows_req_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        req_valid_i |=> (rsp_valid_o && (rsp_slot_o == $past(req_slot_i))));
    assert_no_spurious_rsp_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_valid_i |=> !rsp_valid_o);

    // R7: an own-slot request is never granted.
    assert_own_slot_refused_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_valid_i && (req_slot_i == self_slot_i)) |=> (rsp_status_o == 2'd2));

    // R6: refused responses carry no address.
    assert_refused_no_addr_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (rsp_valid_o && (rsp_status_o != 2'd0)) |-> (rsp_addr_o == '0));

    // R4: an exact fit is not restarted.
    assert_exact_fit_kept_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (accept && ((OFF_W+LEN_W)'(cur_off) + (OFF_W+LEN_W)'(req_len_i)
                    == (OFF_W+LEN_W)'(1) << SUBWIN_LOG2)) |-> !restart);
endmodule

// File: tb/test_win_alloc.sv
module test_win_alloc;
    localparam int NS    = 8;
    localparam int AW    = 32;
    localparam int SWL   = 4;
    localparam int LW    = 8;
    localparam int SW    = 1 << SWL;
    localparam int SLW   = 3;
    localparam logic [AW-1:0] BASE = 32'h4000_0000;
    localparam logic [SLW-1:0] SELF = 3'd5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clear = 1'b0;
    logic req_valid = 1'b0;
    logic [SLW-1:0] req_slot = '0;
    logic [LW-1:0]  req_len = '0;
    logic           rsp_valid;
    logic [AW-1:0]  rsp_addr;
    logic [1:0]     rsp_status;
    logic [SLW-1:0] rsp_slot;

    always #2 clk = ~clk;

    win_alloc #(.NUM_SLOTS(NS), .ADDR_W(AW), .SUBWIN_LOG2(SWL), .LEN_W(LW)) i_win_alloc (
        .clk_i(clk), .rst_i(rst), .base_i(BASE), .self_slot_i(SELF),
        .clear_i(clear), .req_valid_i(req_valid), .req_slot_i(req_slot),
        .req_len_i(req_len), .rsp_valid_o(rsp_valid), .rsp_addr_o(rsp_addr),
        .rsp_status_o(rsp_status), .rsp_slot_o(rsp_slot)
    );

    int checks = 0;
    int errors = 0;
    int model_off [NS];

    logic [AW-1:0]  exp_addr_q [$];
    logic [1:0]     exp_st_q   [$];
    logic [SLW-1:0] exp_slot_q [$];
    string          exp_tag_q  [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Driver: set inputs at a falling edge, push the expected result, wait one cycle.
    task automatic send(input int slot, input int len, input bit clr, input string tag);
        logic [AW-1:0] a;
        logic [1:0]    st;
        int            start;
        if (clr) for (int i = 0; i < NS; i++) model_off[i] = 0;
        a = '0;
        if (slot == int'(SELF)) st = 2'd2;
        else if (len == 0 || len > SW) st = 2'd1;
        else begin
            st    = 2'd0;
            start = (model_off[slot] + len > SW) ? 0 : model_off[slot];
            a     = BASE + AW'(slot * SW + start);
            model_off[slot] = start + len;
        end
        exp_addr_q.push_back(a);
        exp_st_q.push_back(st);
        exp_slot_q.push_back(SLW'(slot));
        exp_tag_q.push_back(tag);
        req_valid = 1'b1;
        req_slot  = SLW'(slot);
        req_len   = LW'(len);
        clear     = clr;
        @(negedge clk);
        clear     = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        clear     = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_clear();
        for (int i = 0; i < NS; i++) model_off[i] = 0;
        req_valid = 1'b0;
        clear     = 1'b1;
        @(negedge clk);
        clear     = 1'b0;
    endtask

    // Monitor: pop and compare on every falling edge after reset.
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_addr_q.size() == 0) begin
                check(1'b0, "R2", "unexpected response", 1, 0);
            end else begin
                automatic logic [AW-1:0]  ea = exp_addr_q.pop_front();
                automatic logic [1:0]     es = exp_st_q.pop_front();
                automatic logic [SLW-1:0] el = exp_slot_q.pop_front();
                automatic string          et = exp_tag_q.pop_front();
                check(rsp_addr == ea, et, "addr", rsp_addr, ea);
                check(rsp_status == es, et, "status", rsp_status, es);
                check(rsp_slot == el, "R2", "slot echo", rsp_slot, el);
            end
        end
    end

    initial begin
        for (int i = 0; i < NS; i++) model_off[i] = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rsp_valid == 1'b0, "R1", "valid after reset", rsp_valid, 0);

        send(0, 5, 0, "R1");          // base
        send(0, 6, 0, "R3");          // +5
        send(0, 5, 0, "R4 exact fit");// +11, ends at 16
        send(0, 1, 0, "R4 restart");  // back to 0
        idle(2);
        send(3, 10, 0, "R5");
        send(0, 3, 0, "R5");          // slot 0 at offset 1
        send(3, 7, 0, "R4 restart");  // 17 > 16
        send(1, 0, 0, "R6 zero len");
        send(1, 17, 0, "R6 long len");
        send(1, 4, 0, "R6 untouched");
        send(5, 2, 0, "R7 own slot");
        send(5, 0, 0, "R7 precedence");
        send(7, 16, 0, "R9 full window");
        send(7, 1, 0, "R9 restart");
        idle(1);
        send(2, 9, 0, "R8 setup");
        do_clear();
        send(0, 4, 0, "R8 after clear");
        send(2, 3, 0, "R8 after clear");
        send(4, 6, 0, "R8 setup");
        send(4, 5, 1, "R8 clear with req");
        send(4, 2, 0, "R8 advance kept");
        idle(2);
        begin
            automatic logic [15:0] rnd = 16'hACE1;
            for (int k = 0; k < 60; k++) begin
                rnd = rnd * 16'd25173 + 16'd13849;
                send(int'(rnd[2:0]), int'(rnd[12:8] % 20), 0, "R3/R4/R5 stream");
            end
        end
        idle(3);
        check(exp_addr_q.size() == 0, "R2", "missing responses", exp_addr_q.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule